// File: doc/BRIEF.md
# History-Indexed Indirect Jump Target Predictor

This block supplies a predicted destination for register-indirect jumps, whose destination can change from one execution to the next. It holds a table of entries. Each entry has a valid flag, a short tag taken from the jump address, and a destination. The table row is chosen by XOR-ing word-address bits of the jump with a global branch history value. The history value is an input, because this block does not keep it. As a result, a single jump can hold a different destination for each recent-history context it runs under. Unrelated jumps that fold onto the same row compete for it, and the tag tells them apart.

The fetch side presents a jump address and the current history on the lookup port. One cycle later the block answers with a hit flag and a destination. On a miss the fetch side uses its own default next address. When the jump resolves, the back end writes the real destination through the update port, using the same address and history the lookup used. A synchronous clear input empties the table in one cycle, for example on a context switch. The block predicts no direction.

Top module: `ind_target_pred`

## Requirements
- R1: While reset is asserted and after it is released, every entry is invalid and `rsp_valid` and `rsp_hit` are 0.
- R2: A lookup sampled at a rising edge is answered at the next edge: `rsp_valid` is 1 exactly in the cycle after `lk_valid` was 1.
- R3: The row index is PC bits [IDX_W+1:2] XOR the history folded to IDX_W bits, where history bit i is XOR-ed into index bit (i mod IDX_W). The tag is PC bits [IDX_W+TAG_W+1:IDX_W+2]. With the defaults (IDX_W=6, TAG_W=8, HIST_W=10), history bits 6 and 0 both land on index bit 0.
- R4: A lookup hits when the selected row is valid and its stored tag equals the lookup tag. `rsp_target` is then the stored destination.
- R5: On a miss, `rsp_hit` is 0 and `rsp_target` is 0.
- R6: An update writes the resolved destination and the update tag into the selected row and marks it valid. A later update to the same row replaces the earlier one.
- R7: The same jump address under two histories that select different rows keeps both destinations at once.
- R8: A lookup whose row is valid but holds a different tag misses. An update from that other address takes the row over.
- R9: `clr` invalidates every row at the next edge. When `clr` and an update are in the same cycle, the clear wins and the row stays invalid.
- R10: A lookup in the same cycle as an update or a clear sees the table as it was before that edge.
- R11: `rsp_hit` is never 1 while `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all rows |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Jump address to look up |
| lk_hist | input | HIST_W | Global history at lookup |
| rsp_valid | output | 1 | Answer for the previous cycle's lookup |
| rsp_hit | output | 1 | Prediction available |
| rsp_target | output | TGT_W | Predicted destination, 0 on a miss |
| upd_valid | input | 1 | Resolved-jump write request |
| upd_pc | input | PC_W | Address of the resolved jump |
| upd_hist | input | HIST_W | History used at its lookup |
| upd_target | input | TGT_W | Resolved destination |

## Verification
The assertions check on every cycle that an answer follows each lookup by one cycle and that no answer appears otherwise. They also check that a hit never appears without an answer, that a miss drives a zero destination, that at most one row is written per cycle, that a write lands with its destination, and that a clear leaves no row valid. Only the bench scenarios can show that index and tag are taken from the right bits with the history folded correctly. The same holds for several histories of one jump coexisting, for aliasing addresses being told apart by tag, for the ordering of a lookup against a same-cycle write or clear, and for clear winning over update. The bench covers these with directed cases and a long random run against its own table model.

// File: rtl/itp_pkg.sv
package itp_pkg;
  localparam int unsigned DEF_PC_W   = 32;
  localparam int unsigned DEF_HIST_W = 10;
  localparam int unsigned DEF_IDX_W  = 6;
  localparam int unsigned DEF_TAG_W  = 8;
  localparam int unsigned DEF_TGT_W  = 32;

  typedef enum logic [1:0] {
    RSP_IDLE = 2'd0,
    RSP_MISS = 2'd1,
    RSP_HIT  = 2'd2
  } rsp_kind_e;
endpackage

// File: rtl/itp_hash.sv
module itp_hash #(
  parameter int unsigned PC_W   = itp_pkg::DEF_PC_W,
  parameter int unsigned HIST_W = itp_pkg::DEF_HIST_W,
  parameter int unsigned IDX_W  = itp_pkg::DEF_IDX_W,
  parameter int unsigned TAG_W  = itp_pkg::DEF_TAG_W
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);
  localparam int unsigned IDX_LO = 2;
  localparam int unsigned TAG_LO = IDX_LO + IDX_W;
  localparam int unsigned USED_TOP = TAG_LO + TAG_W;

  // history bit i lands on index bit (i mod IDX_W)
  function automatic logic [IDX_W-1:0] fold_hist(input logic [HIST_W-1:0] h);
    logic [IDX_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < HIST_W; i++) begin
      acc[i % IDX_W] = acc[i % IDX_W] ^ h[i];
    end
    return acc;
  endfunction

  function automatic logic [IDX_W-1:0] row_of(input logic [PC_W-1:0] p,
                                              input logic [HIST_W-1:0] h);
    return p[TAG_LO-1:IDX_LO] ^ fold_hist(h);
  endfunction

  assign idx = row_of(pc, hist);
  assign tag = pc[USED_TOP-1:TAG_LO];

  logic unused_pc_bits;
  generate
    if (PC_W > USED_TOP) begin : g_hi
      assign unused_pc_bits = ^{pc[IDX_LO-1:0], pc[PC_W-1:USED_TOP]};
    end else begin : g_nohi
      assign unused_pc_bits = ^pc[IDX_LO-1:0];
    end
  endgenerate
endmodule

// File: rtl/itp_store.sv
module itp_store #(
  parameter int unsigned IDX_W = itp_pkg::DEF_IDX_W,
  parameter int unsigned TAG_W = itp_pkg::DEF_TAG_W,
  parameter int unsigned TGT_W = itp_pkg::DEF_TGT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TGT_W-1:0] wr_tgt,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [TGT_W-1:0] rd_tgt
);
  localparam int unsigned ROWS = 1 << IDX_W;

  logic [ROWS-1:0]  valid_q;
  logic [ROWS-1:0]  wr_sel;
  logic [TAG_W-1:0] tag_q [ROWS];
  logic [TGT_W-1:0] tgt_q [ROWS];

  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign wr_sel[r] = wr_en && !clr && (wr_idx == IDX_W'(r));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (clr) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_q | wr_sel;
    end
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++) begin
      if (wr_sel[r]) begin
        tag_q[r] <= wr_tag;
        tgt_q[r] <= wr_tgt;
      end
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_tgt   = tgt_q[rd_idx];

  assert_one_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));

  assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> (valid_q[$past(wr_idx)] && tgt_q[$past(wr_idx)] == $past(wr_tgt)
                         && tag_q[$past(wr_idx)] == $past(wr_tag)));

  assert_clear_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (valid_q == '0));
endmodule

// File: rtl/itp_resp.sv
module itp_resp #(
  parameter int unsigned TAG_W = itp_pkg::DEF_TAG_W,
  parameter int unsigned TGT_W = itp_pkg::DEF_TGT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             row_valid,
  input  logic [TAG_W-1:0] row_tag,
  input  logic [TGT_W-1:0] row_tgt,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [TGT_W-1:0] rsp_target
);
  import itp_pkg::*;

  function automatic rsp_kind_e classify(input logic req, input logic v,
                                         input logic [TAG_W-1:0] a,
                                         input logic [TAG_W-1:0] b);
    if (!req)            return RSP_IDLE;
    else if (v && a == b) return RSP_HIT;
    else                 return RSP_MISS;
  endfunction

  rsp_kind_e kind_d;
  assign kind_d = classify(lk_valid, row_valid, row_tag, lk_tag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_target <= '0;
    end else begin
      rsp_valid  <= (kind_d != RSP_IDLE);
      rsp_hit    <= (kind_d == RSP_HIT);
      rsp_target <= (kind_d == RSP_HIT) ? row_tgt : '0;
    end
  end

  assert_answer_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  assert_no_stray_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);

  assert_hit_needs_answer_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  assert_miss_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_target == '0));
endmodule

// File: rtl/ind_target_pred.sv
module ind_target_pred #(
  parameter int unsigned PC_W   = itp_pkg::DEF_PC_W,
  parameter int unsigned HIST_W = itp_pkg::DEF_HIST_W,
  parameter int unsigned IDX_W  = itp_pkg::DEF_IDX_W,
  parameter int unsigned TAG_W  = itp_pkg::DEF_TAG_W,
  parameter int unsigned TGT_W  = itp_pkg::DEF_TGT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic [HIST_W-1:0] lk_hist,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [TGT_W-1:0]  rsp_target,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic [TGT_W-1:0]  upd_target
);
  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic             row_valid;
  logic [TAG_W-1:0] row_tag;
  logic [TGT_W-1:0] row_tgt;

  itp_hash #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_hash_lk (
    .pc(lk_pc), .hist(lk_hist), .idx(lk_idx), .tag(lk_tag)
  );

  itp_hash #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_hash_up (
    .pc(upd_pc), .hist(upd_hist), .idx(up_idx), .tag(up_tag)
  );

  itp_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_en(upd_valid), .wr_idx(up_idx), .wr_tag(up_tag), .wr_tgt(upd_target),
    .rd_idx(lk_idx), .rd_valid(row_valid), .rd_tag(row_tag), .rd_tgt(row_tgt)
  );

  itp_resp #(.TAG_W(TAG_W), .TGT_W(TGT_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_tag(lk_tag),
    .row_valid(row_valid), .row_tag(row_tag), .row_tgt(row_tgt),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_target(rsp_target)
  );

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rsp_valid && !rsp_hit));
endmodule

// File: tb/ind_target_pred_tb.sv
module ind_target_pred_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic [9:0]  lk_hist = '0;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_target;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic [9:0]  upd_hist = '0;
  logic [31:0] upd_target = '0;

  always #4 clk = ~clk;

  ind_target_pred u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_hist(lk_hist),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_target(rsp_target),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_hist(upd_hist), .upd_target(upd_target)
  );

  typedef struct {
    logic        v;
    logic        hit;
    logic [31:0] tgt;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 0;
  logic        m_v   [64];
  logic [7:0]  m_tag [64];
  logic [31:0] m_tgt [64];

  // row: word bits 7:2, history low six bits, history high four bits on the bottom
  function automatic logic [5:0] b_row(input logic [31:0] pc, input logic [9:0] h);
    return pc[7:2] ^ h[5:0] ^ {2'b00, h[9:6]};
  endfunction

  function automatic logic [7:0] b_tag(input logic [31:0] pc);
    return pc[15:8];
  endfunction

  task automatic step(input logic lv, input logic [31:0] lp, input logic [9:0] lh,
                      input logic uv, input logic [31:0] up, input logic [9:0] uh,
                      input logic [31:0] ut, input logic c, input string req);
    exp_t e;
    logic [5:0] r;
    @(negedge clk);
    lk_valid = lv; lk_pc = lp; lk_hist = lh;
    upd_valid = uv; upd_pc = up; upd_hist = uh; upd_target = ut; clr = c;
    r = b_row(lp, lh);
    e.v   = lv;
    e.hit = lv && m_v[r] && (m_tag[r] == b_tag(lp));
    e.tgt = e.hit ? m_tgt[r] : 32'h0;
    e.req = req;
    sb.push_back(e);
    if (c) begin
      for (int i = 0; i < 64; i++) m_v[i] = 1'b0;
    end else if (uv) begin
      m_v[b_row(up, uh)]   = 1'b1;
      m_tag[b_row(up, uh)] = b_tag(up);
      m_tgt[b_row(up, uh)] = ut;
    end
  endtask

  task automatic look(input logic [31:0] p, input logic [9:0] h, input string req);
    step(1'b1, p, h, 1'b0, 32'h0, 10'h0, 32'h0, 1'b0, req);
  endtask

  task automatic upd(input logic [31:0] p, input logic [9:0] h, input logic [31:0] t,
                     input string req);
    step(1'b0, 32'h0, 10'h0, 1'b1, p, h, t, 1'b0, req);
  endtask

  task automatic idle(input string req);
    step(1'b0, 32'h0, 10'h0, 1'b0, 32'h0, 10'h0, 32'h0, 1'b0, req);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // monitor: two ns after each rising edge, compare against the oldest expectation
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_cmp++;
        if (rsp_valid !== e.v || rsp_hit !== e.hit || rsp_target !== e.tgt) begin
          n_bad++;
          $display("FAIL %s: valid/hit/target got %0b/%0b/%h exp %0b/%0b/%h",
                   e.req, rsp_valid, rsp_hit, rsp_target, e.v, e.hit, e.tgt);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got hung exp done");
      summary();
      $finish;
    end
  end

  localparam logic [31:0] PA = 32'h0000_1A40;
  localparam logic [31:0] PB = PA ^ 32'h0000_0100; // same row bits, other tag
  localparam logic [31:0] PC = 32'h0000_3300;

  initial begin
    for (int i = 0; i < 64; i++) begin
      m_v[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    n_cmp++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: in reset valid/hit got %0b/%0b exp 0/0", rsp_valid, rsp_hit);
    end
    @(negedge clk);
    rst_n = 1'b1;

    idle("R1 idle after reset");
    look(PA, 10'h000, "R1 empty table miss");
    look(PC, 10'h155, "R5 empty miss zero target");

    upd(PA, 10'h000, 32'hAAAA_0001, "R6 write");
    look(PA, 10'h000, "R4 hit after write");
    upd(PA, 10'h003, 32'hAAAA_0002, "R7 second context");
    look(PA, 10'h000, "R7 first context kept");
    look(PA, 10'h003, "R7 second context hit");

    look(PB, 10'h000, "R8 alias tag mismatch");
    upd(PB, 10'h000, 32'hBBBB_0001, "R8 alias takeover");
    look(PB, 10'h000, "R8 alias hit");
    look(PA, 10'h000, "R8 evicted miss");

    upd(PC, 10'h001, 32'hCCCC_0001, "R3 fold write");
    look(PC, 10'h040, "R3 bit6 folds onto bit0");
    look(PC, 10'h041, "R3 folded bits cancel");

    upd(PA, 10'h003, 32'hAAAA_0003, "R6 overwrite");
    look(PA, 10'h003, "R6 newest wins");

    step(1'b1, PA, 10'h003, 1'b1, PA, 10'h003, 32'hAAAA_0004, 1'b0, "R10 read old on write");
    look(PA, 10'h003, "R10 new visible next");

    idle("R2 no request no answer");
    idle("R11 idle no hit");

    step(1'b1, PC, 10'h001, 1'b0, 32'h0, 10'h0, 32'h0, 1'b1, "R10 read old on clear");
    look(PC, 10'h001, "R9 cleared miss");
    look(PA, 10'h003, "R9 cleared miss 2");

    upd(PA, 10'h000, 32'hAAAA_0005, "R9 rewrite");
    step(1'b0, 32'h0, 10'h0, 1'b1, PA, 10'h000, 32'hAAAA_0006, 1'b1, "R9 clear beats update");
    look(PA, 10'h000, "R9 clear won");

    for (int k = 0; k < 400; k++) begin
      logic [31:0] rv, p;
      logic [9:0]  h;
      rv = $urandom();
      p = 32'h0000_4000 | {16'h0, 6'h0, rv[1:0], 6'h0, rv[4:2], 2'b00};
      h = {rv[14:13], 5'h0, rv[7:5]};
      case (rv[10:8])
        3'd0, 3'd1: step(1'b0, 32'h0, 10'h0, 1'b1, p, h, rv ^ 32'h5A5A_0000, 1'b0, "R6 random write");
        3'd2:       step(1'b1, p, h, 1'b1, p ^ {rv[15], 7'h0, 2'b0}, h, rv, rv[20] & rv[21] & rv[22], "R10 random mixed");
        3'd3:       idle("R2 random idle");
        default:    look(p, h, "R4 random lookup");
      endcase
    end

    idle("R2 drain");
    idle("R2 drain");
    @(posedge clk);
    #3;
    done = 1;
    summary();
    $finish;
  end
endmodule